// File: doc/BRIEF.md
# Parallel tree-reduction schedule generator

This block produces, one pair per cycle, the fixed order of element operations that folds a vector into a single value by a binary tree. Each emitted pair names a left element and a right element; the consumer computes `left <= op(left, right)`, so the schedule works in place and every partial result stays in a vector element. The length does not have to be a power of two, and the schedule is identical every time for the same inputs. Because every intermediate result is written back, an interrupted run can resume at the next pair.

A start pulse captures the length, a two-bit inversion control and an optional predicate mask. The block first builds a compact list of the active element positions. It then walks the tree over those positions, so masked-out elements are skipped and never named. Pairs leave through a registered valid/ready stream, and a done flag rises once the last pair has been taken. Control bit 0 mirrors the pairing so that the result gathers in the last active element rather than the first. Control bit 1 runs the pairing distances from large to small rather than from small to large.

Top module: `rd_tree_sched`

## Requirements
- R1: After reset, `out_valid` and `done` are 0.
- R2: With M active elements, exactly max(M-1,0) pairs are issued, which is at most 127. `done` rises within two cycles after the last pair is accepted and is never 1 while `out_valid` is 1.
- R3: Let p[0..M-1] be the active indices in ascending order. With `inv[1]=0` and `inv[0]=0`, the passes use distance d = 1, 2, 4, ... while d < M. Within a pass, k runs upward over the multiples of 2d with k+d < M, and each step emits left=p[k], right=p[k+d]. Every left index is therefore below its right index.
- R4: With `inv[0]=1`, each emitted pair is left=p[M-1-k], right=p[M-1-k-d] for the same (k,d) order as the unmirrored case. The inner walk therefore runs from high indices down, and every left index is above its right index.
- R5: With `inv[1]=1`, d starts at P/2, where P is the smallest power of two not below M, and halves down to 1. Within a pass, k runs 0..d-1, and a pair is emitted only where k+d < M.
- R6: With `pred_en=1`, an element i is active only if i < `len` and `pred_mask[i]=1`. With `pred_en=0`, every i < `len` is active.
- R7: With fewer than two active elements, no pair is issued and `done` still rises.
- R8: While `out_valid=1` and `out_ready=0`, the pair on the outputs stays unchanged on the next cycle.
- R9: A `start` pulse during a run drops any pending pair. The next cycle has `out_valid=0` and `done=0`, and the new schedule runs from its beginning.
- R10: Applying the pairs in order leaves the combined value of all active elements in p[0] when `inv[0]=0` and in p[M-1] when `inv[0]=1`.
- R11: An index named in an emitted pair always belongs to an active element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures the inputs and (re)starts the schedule |
| len | input | CW | Vector length, 0..MAX_LEN |
| inv | input | 2 | Bit 0: mirror the pairing; bit 1: shrinking distances |
| pred_en | input | 1 | Apply `pred_mask` |
| pred_mask | input | MAX_LEN | Per-element active bits |
| out_ready | input | 1 | Consumer accepts the current pair |
| out_valid | output | 1 | A pair is on the outputs |
| out_left | output | IW | Destination/left element index |
| out_right | output | IW | Right operand element index |
| done | output | 1 | Schedule finished, held until the next start |

## Verification
A wrong distance or base counter shows up at the ports at once. The very next emitted pair leaves the expected list, and a skipped pass gives a short pair count or a final value in the wrong element. A stale or shifted active-position list shows up as an index whose predicate bit is clear, as early as the first pair after start. A handshake fault shows up one cycle after a stalled pair, as a changed pair or a duplicated or dropped pair in the sequence.

// File: rtl/rd_sched_pkg.sv
package rd_sched_pkg;

  typedef enum logic {
    STEP_GROW   = 1'b0,
    STEP_SHRINK = 1'b1
  } rd_step_e;

  // smallest power of two that is not below n (n=0 gives 1)
  function automatic int unsigned rd_pow2_ceil(int unsigned n);
    int unsigned p;
    p = 1;
    for (int b = 0; b < 31; b++) begin
      if (p < n) p = p << 1;
    end
    return p;
  endfunction

endpackage

// File: rtl/rd_compact.sv
module rd_compact #(
  parameter int MAX_LEN = 32,
  localparam int IW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int CW = $clog2(MAX_LEN + 1)
) (
  input  logic [CW-1:0]              len,
  input  logic                       pred_en,
  input  logic [MAX_LEN-1:0]         pred_mask,
  output logic [MAX_LEN-1:0][IW-1:0] pos,
  output logic [CW-1:0]              cnt
);

  // packs the indices of active elements into ascending slots
  always_comb begin
    pos = '0;
    cnt = '0;
    for (int i = 0; i < MAX_LEN; i++) begin
      if ((CW'(i) < len) && (!pred_en || pred_mask[i])) begin
        pos[cnt[IW-1:0]] = IW'(i);
        cnt = cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/rd_stride_walk.sv
module rd_stride_walk
  import rd_sched_pkg::*;
#(
  parameter int MAX_LEN = 32,
  localparam int CW = $clog2(MAX_LEN + 1),
  localparam int DW = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] cnt,
  input  rd_step_e      dir,
  input  logic          adv,
  output logic          busy,
  output logic          cand_ok,
  output logic [DW-1:0] k,
  output logic [DW-1:0] d
);

  logic [DW-1:0] m_r;
  rd_step_e      dir_r;
  logic [DW-1:0] d_init;
  logic [DW-1:0] k_next;
  logic [DW-1:0] d_dbl;
  logic          step;

  assign d_init  = (dir == STEP_SHRINK) ?
                   DW'(rd_pow2_ceil(32'(cnt)) >> 1) : DW'(1);
  assign cand_ok = busy && ((k + d) < m_r);
  assign step    = busy && (!cand_ok || adv);
  assign k_next  = k + (d << 1);
  assign d_dbl   = d << 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      k     <= '0;
      d     <= '0;
      m_r   <= '0;
      dir_r <= STEP_GROW;
    end else if (load) begin
      busy  <= (cnt > CW'(1));
      k     <= '0;
      d     <= d_init;
      m_r   <= DW'(cnt);
      dir_r <= dir;
    end else if (step) begin
      if (dir_r == STEP_GROW) begin
        if ((k_next + d) < m_r) begin
          k <= k_next;
        end else if (d_dbl >= m_r) begin
          busy <= 1'b0;
        end else begin
          k <= '0;
          d <= d_dbl;
        end
      end else begin
        if ((k + DW'(1)) < d) begin
          k <= k + DW'(1);
        end else if (d <= DW'(1)) begin
          busy <= 1'b0;
        end else begin
          k <= '0;
          d <= d >> 1;
        end
      end
    end
  end

endmodule

// File: rtl/rd_tree_sched.sv
module rd_tree_sched
  import rd_sched_pkg::*;
#(
  parameter int MAX_LEN = 32,
  localparam int IW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int CW = $clog2(MAX_LEN + 1),
  localparam int DW = CW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CW-1:0]      len,
  input  logic [1:0]         inv,
  input  logic               pred_en,
  input  logic [MAX_LEN-1:0] pred_mask,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [IW-1:0]      out_left,
  output logic [IW-1:0]      out_right,
  output logic               done
);

  logic [MAX_LEN-1:0][IW-1:0] pos_w;
  logic [MAX_LEN-1:0][IW-1:0] pos_r;
  logic [CW-1:0]              cnt_w;
  logic [DW-1:0]              cnt_r;
  logic                       mirror_r;
  logic                       armed_r;
  logic                       busy;
  logic                       cand_ok;
  logic [DW-1:0]              k;
  logic [DW-1:0]              d;
  logic [DW-1:0]              li;
  logic [DW-1:0]              ri;
  logic                       take;

  rd_compact #(.MAX_LEN(MAX_LEN)) u_compact (
    .len       (len),
    .pred_en   (pred_en),
    .pred_mask (pred_mask),
    .pos       (pos_w),
    .cnt       (cnt_w)
  );

  rd_stride_walk #(.MAX_LEN(MAX_LEN)) u_walk (
    .clk     (clk),
    .rst     (rst),
    .load    (start),
    .cnt     (cnt_w),
    .dir     (inv[1] ? STEP_SHRINK : STEP_GROW),
    .adv     (take),
    .busy    (busy),
    .cand_ok (cand_ok),
    .k       (k),
    .d       (d)
  );

  // position slots for the candidate pair, mirrored when requested
  assign li   = mirror_r ? (cnt_r - DW'(1) - k)     : k;
  assign ri   = mirror_r ? (cnt_r - DW'(1) - k - d) : (k + d);
  assign take = !start && cand_ok && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (start) begin
      pos_r    <= pos_w;
      cnt_r    <= DW'(cnt_w);
      mirror_r <= inv[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (start) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_left  <= pos_r[li[IW-1:0]];
      out_right <= pos_r[ri[IW-1:0]];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      armed_r <= 1'b0;
    end else if (start) begin
      done    <= 1'b0;
      armed_r <= 1'b1;
    end else if (armed_r && !busy && !out_valid) begin
      done    <= 1'b1;
      armed_r <= 1'b0;
    end
  end

endmodule

// File: rtl/rd_tree_sched_chk.sv
module rd_tree_sched_chk #(
  parameter int MAX_LEN = 32,
  localparam int IW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [1:0]         inv,
  input logic               pred_en,
  input logic [MAX_LEN-1:0] pred_mask,
  input logic               out_ready,
  input logic               out_valid,
  input logic [IW-1:0]      out_left,
  input logic [IW-1:0]      out_right,
  input logic               done
);

  logic [7:0]         issued;
  logic               mir_q;
  logic               pe_q;
  logic [MAX_LEN-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      issued <= '0;
      mir_q  <= 1'b0;
      pe_q   <= 1'b0;
      mask_q <= '0;
    end else if (start) begin
      issued <= '0;
      mir_q  <= inv[0];
      pe_q   <= pred_en;
      mask_q <= pred_mask;
    end else if (out_valid && out_ready) begin
      issued <= issued + 8'd1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !done));

  a_r2_op_cap: assert property (@(posedge clk) disable iff (rst)
    (issued <= 8'd127) && (32'(issued) <= MAX_LEN - 1));

  a_r2_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid);

  a_r3_left_below: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !mir_q) |-> (out_left < out_right));

  a_r4_left_above: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mir_q) |-> (out_left > out_right));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !start) |=>
      (out_valid && $stable(out_left) && $stable(out_right)));

  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    start |=> (!out_valid && !done));

  a_r11_active_only: assert property (@(posedge clk) disable iff (rst)
    (out_valid && pe_q) |-> (mask_q[out_left] && mask_q[out_right]));

endmodule

bind rd_tree_sched rd_tree_sched_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .inv       (inv),
  .pred_en   (pred_en),
  .pred_mask (pred_mask),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_left  (out_left),
  .out_right (out_right),
  .done      (done)
);

// File: tb/rd_tree_sched_tb.sv
module rd_tree_sched_tb;

  localparam int MAX_LEN = 32;
  localparam int IW = 5;
  localparam int CW = 6;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start = 1'b0;
  logic [CW-1:0]      len = '0;
  logic [1:0]         inv = '0;
  logic               pred_en = 1'b0;
  logic [MAX_LEN-1:0] pred_mask = '0;
  logic               out_ready = 1'b0;
  logic               out_valid;
  logic [IW-1:0]      out_left;
  logic [IW-1:0]      out_right;
  logic               done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // expected schedule
  int exp_l [0:127];
  int exp_r [0:127];
  int exp_n;
  int act_pos [0:MAX_LEN-1];
  int act_m;
  bit act_bit [0:MAX_LEN-1];
  int vals [0:MAX_LEN-1];
  bit cur_mirror;
  string cur_tag;

  always #4 clk = ~clk;

  rd_tree_sched #(.MAX_LEN(MAX_LEN)) u_dut (
    .clk (clk), .rst (rst), .start (start), .len (len), .inv (inv),
    .pred_en (pred_en), .pred_mask (pred_mask), .out_ready (out_ready),
    .out_valid (out_valid), .out_left (out_left), .out_right (out_right),
    .done (done)
  );

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic add_pair(int k, int d);
    if (cur_mirror) begin
      exp_l[exp_n] = act_pos[act_m-1-k];
      exp_r[exp_n] = act_pos[act_m-1-k-d];
    end else begin
      exp_l[exp_n] = act_pos[k];
      exp_r[exp_n] = act_pos[k+d];
    end
    exp_n++;
  endtask

  // R3/R4/R5/R6 reference schedule from the requirement text
  task automatic build(int n, logic [1:0] iv, bit pe, logic [MAX_LEN-1:0] m);
    int p2;
    act_m = 0;
    exp_n = 0;
    cur_mirror = iv[0];
    cur_tag = iv[1] ? "R5" : (iv[0] ? "R4" : "R3");
    for (int i = 0; i < MAX_LEN; i++) begin
      act_bit[i] = (i < n) && (!pe || m[i]);
      if (act_bit[i]) begin
        act_pos[act_m] = i;
        act_m++;
      end
    end
    if (!iv[1]) begin
      for (int d = 1; d < act_m; d = d * 2)
        for (int k = 0; k + d < act_m; k = k + 2 * d) add_pair(k, d);
    end else begin
      p2 = 1;
      while (p2 < act_m) p2 = p2 * 2;
      for (int d = p2 / 2; d >= 1; d = d / 2)
        for (int k = 0; k < d; k++) if (k + d < act_m) add_pair(k, d);
    end
  endtask

  task automatic kick(int n, logic [1:0] iv, bit pe, logic [MAX_LEN-1:0] m);
    @(negedge clk);
    len = CW'(n); inv = iv; pred_en = pe; pred_mask = m;
    start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(!out_valid && !done, "R9 start clears stream", int'(out_valid), 0);
    for (int i = 0; i < MAX_LEN; i++) vals[i] = 3 * i + 1;
  endtask

  // collects up to lim pairs; full run when lim < 0
  task automatic collect(int lim, int stall);
    int got = 0, t = 0, pl = 0, pr = 0, target, sum;
    bit hold = 0, rdy;
    while (!done && (lim < 0 || got < lim) && t < 4000) begin
      if (hold) begin
        check(out_valid && out_left == pl && out_right == pr,
              "R8 stalled pair held", int'(out_left), pl);
      end
      rdy = (stall == 0) || (((t * 7 + 3) % stall) != 0);
      out_ready = rdy;
      if (out_valid && rdy) begin
        if (got < exp_n) begin
          check(out_left == exp_l[got] && out_right == exp_r[got],
                {cur_tag, " pair order"}, int'(out_left) * 100 + int'(out_right),
                exp_l[got] * 100 + exp_r[got]);
        end else begin
          check(1'b0, "R2 extra pair", got, exp_n);
        end
        check(act_bit[out_left] && act_bit[out_right], "R11 active index",
              int'(out_left), int'(out_right));
        vals[out_left] = vals[out_left] + vals[out_right];
        got++;
      end
      hold = out_valid && !rdy;
      pl = out_left; pr = out_right;
      t++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    if (lim >= 0) return;
    check(done == 1'b1, "R2 done raised", int'(done), 1);
    check(got == exp_n, "R2 pair count", got, exp_n);
    check(!out_valid, "R2 no pair with done", int'(out_valid), 0);
    if (act_m > 0) begin
      target = cur_mirror ? act_pos[act_m-1] : act_pos[0];
      sum = 0;
      for (int i = 0; i < act_m; i++) sum += 3 * act_pos[i] + 1;
      check(vals[target] == sum, "R10 result location", vals[target], sum);
    end
  endtask

  task automatic run(int n, logic [1:0] iv, bit pe, logic [MAX_LEN-1:0] m, int stall);
    build(n, iv, pe, m);
    kick(n, iv, pe, m);
    collect(-1, stall);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!out_valid && !done, "R1 reset state", int'(out_valid) + int'(done), 0);
    rst = 1'b0;
  endtask

  task automatic t_grow;          // R3
    run(8, 2'b00, 1'b0, '0, 0);
    run(13, 2'b00, 1'b0, '0, 3);
  endtask

  task automatic t_mirror;        // R4
    run(6, 2'b01, 1'b0, '0, 4);
    run(9, 2'b01, 1'b0, '0, 0);
  endtask

  task automatic t_shrink;        // R5
    run(7, 2'b10, 1'b0, '0, 0);
    run(11, 2'b11, 1'b0, '0, 5);
  endtask

  task automatic t_pred;          // R6 R11
    run(12, 2'b00, 1'b1, 32'h0000_0B64, 3);
    run(20, 2'b01, 1'b1, 32'hFFFF_A5A0, 0);
    run(16, 2'b10, 1'b1, 32'hF0F0_3C3C, 4);
  endtask

  task automatic t_short;         // R7
    run(10, 2'b00, 1'b1, 32'h0000_0020, 0);
    check(exp_n == 0, "R7 single active no pairs", exp_n, 0);
    run(1, 2'b01, 1'b0, '0, 0);
    run(0, 2'b10, 1'b0, '0, 0);
  endtask

  task automatic t_full;          // R2 full length
    run(32, 2'b00, 1'b0, '0, 0);
    check(exp_n == 31, "R2 full length count", exp_n, 31);
    run(32, 2'b11, 1'b0, '0, 3);
  endtask

  task automatic t_restart;       // R9
    build(15, 2'b00, 1'b0, '0);
    kick(15, 2'b00, 1'b0, '0);
    collect(3, 0);
    run(10, 2'b01, 1'b1, 32'h0000_03B7, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_grow();
    t_mirror();
    t_shrink();
    t_pred();
    t_short();
    t_full();
    t_restart();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule